// File: doc/BRIEF.md
# Cascadable Dual Down-Counter Timer

This block holds two programmable down-counters of a configurable width (8 bits by default). Each counter has its own reload value, run control, underflow flag and toggling output. Software reaches them through a small register port. Each channel counts one of two sources. The first is a shared count-tick strobe, where each one-cycle pulse marks a falling edge of the prescaled count clock. The second is the rising edges of an external event input. Each underflow reloads the counter, raises the channel's interrupt flag and flips the channel's output toggle.

When chained, the two counters form one counter of twice the width. The low channel carries into the high one. Only the high channel's flag reports the full-width underflow. A low-byte read latches the high byte, so a following high-byte read gives a coherent value. Run and stop requests in tick mode are taken up only at a count tick, and a stop lets one final decrement through. In event mode the run bit acts at once. Each output enable gates its output combinationally, without any synchronisation.

Register map (3-bit address): 0/1 channel control, with bit 0 run, bit 1 output enable and bit 2 event source. 2/3 reload value. 4/5 count, read-only. 6 flags, with bit 0 low channel and bit 1 high channel, write 1 to clear. 7 mode, with bit 0 chaining.

Top module: `cascade_timer`

## Requirements
- R1: In tick mode a written run bit is taken up at the next count tick only. A start consumes that tick without decrementing, and counting begins on the tick after it.
- R2: In tick mode, after 0 is written to the run bit, the next tick still decrements once and the channel then stays stopped.
- R3: Control bit 0 reads 1 from the moment run is written 1 until the channel has actually stopped.
- R4: A running channel decrements by one per tick. A tick at count 0 reloads the reload value on that same edge, so the first underflow comes N+2 ticks after a start from value N, and later ones come every N+1 ticks.
- R5: Writing a reload register while its channel is stopped also presets the counter to that value.
- R6: A channel's flag (register 6, bit 0 low channel, bit 1 high channel) is set by its underflow. Writing 1 clears it, writing 0 leaves it alone, and reset clears it.
- R7: With register 7 bit 0 set, the pair counts as one counter with the high byte at address 5. The low byte wraps to all ones while the high byte is nonzero. At zero both halves reload, flag bit 1 is set and flag bit 0 is never set.
- R8: In chained mode a read of address 4 latches the high byte, and the next read of address 5 returns that latched value even if the counter moved in between.
- R9: With control bit 2 set, the channel counts rising edges of the event input, ignores count ticks, and applies run and stop at once with no extra decrement.
- R10: Each underflow flips the channel's output. While control bit 1 is 0 the output is low, and setting the bit again shows the preserved toggle state at once.
- R11: After reset all registers, counts, flags and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data, valid the cycle after rd_en |
| cnt_tick_i | input | 1 | One-cycle pulse per falling edge of the count clock |
| evt_i | input | 1 | External event input, counted on rising edges |
| tout_o | output | 2 | Gated toggle outputs, bit 0 low channel |
| irq_o | output | 2 | Interrupt flags, bit 0 low channel |

## Verification
A write lands on the clock edge that samples wr_en, and read data appears one cycle after rd_en. A count tick or event edge changes the count, flag and toggle on the edge that samples it. The output enable reaches the outputs combinationally, straight after the control write. The bench drives every stimulus for exactly one cycle between falling edges and samples on the following falling edge, after the edge that must have acted. It then reads the result back through the register port. The underflow period sweep counts ticks one at a time, so any change in the start latency or the reload point shows up as a wrong tick number.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
    localparam int NCH = 2;
    localparam int AW  = 3;

    typedef logic [AW-1:0] ctm_addr_t;

    localparam ctm_addr_t ADR_CTRL   = 3'd0;
    localparam ctm_addr_t ADR_RELOAD = 3'd2;
    localparam ctm_addr_t ADR_COUNT  = 3'd4;
    localparam ctm_addr_t ADR_FLAGS  = 3'd6;
    localparam ctm_addr_t ADR_MODE   = 3'd7;

    // control word: bit 0 run, bit 1 output enable, bit 2 event source
    typedef struct packed {
        logic evt_mode;
        logic out_en;
        logic run_req;
    } ctm_cfg_t;

    typedef enum logic [1:0] {
        SRC_PRESCALE = 2'd0,
        SRC_EVENT    = 2'd1,
        SRC_CHAIN    = 2'd2
    } ctm_src_e;

    function automatic logic [2:0] cfg_view(ctm_cfg_t c, logic run_seen);
        return {c.evt_mode, c.out_en, run_seen};
    endfunction

    function automatic ctm_src_e pick_src(logic chained, logic evt_mode);
        if (chained)  return SRC_CHAIN;
        if (evt_mode) return SRC_EVENT;
        return SRC_PRESCALE;
    endfunction
endpackage

// File: rtl/ctm_channel.sv
module ctm_channel
    import ctm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          run_req_i,
    input  logic          immediate_i,
    input  logic          preset_i,
    input  logic [DW-1:0] preset_val_i,
    input  logic [DW-1:0] reload_i,
    input  logic          reload_at_zero_i,
    output logic [DW-1:0] count_o,
    output logic          run_rd_o,
    output logic          zstep_o,
    output logic          tog_o
);
    logic          running_q;
    logic [DW-1:0] count_q;
    logic          tog_q;
    logic          active;
    logic          step;
    logic          at_zero;

    assign active   = immediate_i ? run_req_i : running_q;
    assign step     = tick_i & active;
    assign at_zero  = (count_q == '0);
    assign zstep_o  = step & at_zero;
    assign run_rd_o = immediate_i ? run_req_i : (run_req_i | running_q);
    assign count_o  = count_q;
    assign tog_o    = tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
        end else if (immediate_i || tick_i) begin
            running_q <= run_req_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (step) begin
            if (at_zero) count_q <= reload_at_zero_i ? reload_i : '1;
            else         count_q <= count_q - DW'(1);
        end else if (preset_i && !run_rd_o) begin
            count_q <= preset_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= tog_q ^ zstep_o;
    end

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !at_zero) |=> (count_q == $past(count_q) - DW'(1)));

    // R1
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!immediate_i && !tick_i) |=> $stable(running_q));

    // R2
    last_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!immediate_i && tick_i && running_q && !run_req_i && !at_zero)
        |=> (!running_q && count_q == $past(count_q) - DW'(1)));

    // R10
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !zstep_o |=> $stable(tog_q));
endmodule

// File: rtl/ctm_regs.sv
module ctm_regs
    import ctm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  ctm_addr_t                addr,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            rd_data,
    input  logic [NCH-1:0][DW-1:0]   cnt_i,
    input  logic [NCH-1:0]           run_rd_i,
    input  logic [NCH-1:0]           set_i,
    output ctm_cfg_t [NCH-1:0]       cfg_o,
    output logic [NCH-1:0][DW-1:0]   reload_o,
    output logic [NCH-1:0]           preset_o,
    output logic [NCH-1:0]           flag_o,
    output logic                     cascade_o
);
    ctm_cfg_t [NCH-1:0]     cfg_q;
    logic [NCH-1:0][DW-1:0] reload_q;
    logic [NCH-1:0]         flag_q;
    logic                   cascade_q;
    logic [DW-1:0]          shadow_q;
    logic [DW-1:0]          rd_q;
    logic [DW-1:0]          rd_next;
    logic                   flag_wr;
    logic                   low_rd;

    assign flag_wr   = wr_en && (addr == ADR_FLAGS);
    assign low_rd    = rd_en && (addr == ADR_COUNT) && cascade_q;
    assign cfg_o     = cfg_q;
    assign reload_o  = reload_q;
    assign flag_o    = flag_q;
    assign cascade_o = cascade_q;
    assign rd_data   = rd_q;

    for (genvar g = 0; g < NCH; g++) begin : g_preset
        localparam ctm_addr_t RL_ADR = ADR_RELOAD + ctm_addr_t'(g);
        assign preset_o[g] = wr_en && (addr == RL_ADR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            reload_q  <= '0;
            flag_q    <= '0;
            cascade_q <= 1'b0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_en && addr == ADR_CTRL + ctm_addr_t'(i))
                    cfg_q[i] <= ctm_cfg_t'(wr_data[2:0]);
                if (wr_en && addr == ADR_RELOAD + ctm_addr_t'(i))
                    reload_q[i] <= wr_data;
                flag_q[i] <= set_i[i] | (flag_q[i] & ~(flag_wr & wr_data[i]));
            end
            if (wr_en && addr == ADR_MODE) cascade_q <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         shadow_q <= '0;
        else if (low_rd) shadow_q <= cnt_i[1];
    end

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADR_CTRL + ctm_addr_t'(i))
                rd_next = DW'(cfg_view(cfg_q[i], run_rd_i[i]));
            if (addr == ADR_RELOAD + ctm_addr_t'(i))
                rd_next = reload_q[i];
            if (addr == ADR_COUNT + ctm_addr_t'(i))
                rd_next = (i == 1 && cascade_q) ? shadow_q : cnt_i[i];
        end
        if (addr == ADR_FLAGS) rd_next = DW'(flag_q);
        if (addr == ADR_MODE)  rd_next = DW'(cascade_q);
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_next;
    end

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_data[0] && !set_i[0]) |=> !flag_q[0]);

    // R6
    w0_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !wr_data[0] && flag_q[0]) |=> flag_q[0]);

    // R7
    casc_lowflag_chk: assert property (@(posedge clk) disable iff (rst)
        (cascade_q && !flag_q[0]) |=> !flag_q[0]);

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !low_rd |=> $stable(shadow_q));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import ctm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          cnt_tick_i,
    input  logic          evt_i,
    output logic [1:0]    tout_o,
    output logic [1:0]    irq_o
);
    ctm_cfg_t [NCH-1:0]     cfg;
    logic [NCH-1:0][DW-1:0] reload;
    logic [NCH-1:0][DW-1:0] count;
    logic [NCH-1:0]         preset;
    logic [NCH-1:0]         run_rd;
    logic [NCH-1:0]         zstep;
    logic [NCH-1:0]         tog;
    logic [NCH-1:0]         tick;
    logic [NCH-1:0]         set_flag;
    logic [NCH-1:0]         flag;
    logic                   cascade;
    logic                   evt_q;
    logic                   evt_pulse;
    ctm_src_e [NCH-1:0]     src;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= 1'b0;
        else     evt_q <= evt_i;
    end
    assign evt_pulse = evt_i & ~evt_q;

    assign src[0] = pick_src(1'b0, cfg[0].evt_mode);
    assign src[1] = pick_src(cascade, cfg[1].evt_mode);

    for (genvar g = 0; g < NCH; g++) begin : g_tick
        always_comb begin
            unique case (src[g])
                SRC_EVENT: tick[g] = evt_pulse;
                SRC_CHAIN: tick[g] = (g == 1) ? zstep[0] : 1'b0;
                default:   tick[g] = cnt_tick_i;
            endcase
        end
        assign tout_o[g] = tog[g] & cfg[g].out_en;
    end

    ctm_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cnt_i     (count),
        .run_rd_i  (run_rd),
        .set_i     (set_flag),
        .cfg_o     (cfg),
        .reload_o  (reload),
        .preset_o  (preset),
        .flag_o    (flag),
        .cascade_o (cascade)
    );

    ctm_channel #(.DW(DW)) u_lo (
        .clk              (clk),
        .rst              (rst),
        .tick_i           (tick[0]),
        .run_req_i        (cfg[0].run_req),
        .immediate_i      (cfg[0].evt_mode),
        .preset_i         (preset[0]),
        .preset_val_i     (wr_data),
        .reload_i         (reload[0]),
        .reload_at_zero_i (!cascade || (count[1] == '0)),
        .count_o          (count[0]),
        .run_rd_o         (run_rd[0]),
        .zstep_o          (zstep[0]),
        .tog_o            (tog[0])
    );

    ctm_channel #(.DW(DW)) u_hi (
        .clk              (clk),
        .rst              (rst),
        .tick_i           (tick[1]),
        .run_req_i        (cascade ? run_rd[0] : cfg[1].run_req),
        .immediate_i      (cascade || cfg[1].evt_mode),
        .preset_i         (preset[1]),
        .preset_val_i     (wr_data),
        .reload_i         (reload[1]),
        .reload_at_zero_i (1'b1),
        .count_o          (count[1]),
        .run_rd_o         (run_rd[1]),
        .zstep_o          (zstep[1]),
        .tog_o            (tog[1])
    );

    assign set_flag = {zstep[1], zstep[0] & ~cascade};
    assign irq_o    = flag;

    // R7
    casc16_chk: assert property (@(posedge clk) disable iff (rst)
        (cascade && zstep[1]) |-> (zstep[0] && count[0] == '0));

    // R9
    evt_ignore_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg[0].evt_mode && !evt_pulse) |=> $stable(count[0]));
endmodule

// File: tb/cascade_timer_tb.sv
`timescale 1ns/1ps
module cascade_timer_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          cnt_tick = 1'b0;
    logic          evt = 1'b0;
    logic [1:0]    tout;
    logic [1:0]    irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    cascade_timer #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .cnt_tick_i(cnt_tick),
        .evt_i(evt), .tout_o(tout), .irq_o(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[2:0]; wr_data = d[DW-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = a[2:0];
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic tick();
        @(negedge clk);
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic evt_edge();
        @(negedge clk);
        evt = 1'b1;
        repeat (2) @(negedge clk);
        evt = 1'b0;
        @(negedge clk);
    endtask

    task automatic stop_lo();
        wr(0, 0);
        tick();
        wr(6, 3);
    endtask

    initial begin
        int v;
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(0, v); chk("R11 ctrl0", v, 0);
        rd(4, v); chk("R11 count0", v, 0);
        rd(6, v); chk("R11 flags", v, 0);
        chk("R11 tout", int'(tout), 0);
        chk("R11 irq", int'(irq), 0);

        // R5 preset while stopped
        wr(2, 'h42);
        rd(4, v); chk("R5 preset", v, 'h42);

        // R1 / R3 start synchronised to tick
        wr(0, 1);
        repeat (3) @(negedge clk);
        rd(4, v); chk("R1 no tick no count", v, 'h42);
        rd(0, v); chk("R3 run read after start", v & 1, 1);
        tick();
        rd(4, v); chk("R1 start tick no decrement", v, 'h42);
        tick();
        rd(4, v); chk("R1 first decrement", v, 'h41);
        tick();
        rd(4, v); chk("R4 decrement", v, 'h40);

        // R2 / R3 stop lets one decrement through
        wr(0, 0);
        rd(0, v); chk("R3 run read while stopping", v & 1, 1);
        rd(4, v); chk("R2 no change before tick", v, 'h40);
        tick();
        rd(4, v); chk("R2 final decrement", v, 'h3F);
        rd(0, v); chk("R3 run read stopped", v & 1, 0);
        tick();
        rd(4, v); chk("R2 stays stopped", v, 'h3F);

        // R4 / R6 sweep of underflow period against reload value
        for (int n = 0; n <= 16; n++) begin
            int nv;
            int first;
            int second;
            nv = (n == 16) ? 255 : n;
            stop_lo();
            wr(2, nv);
            rd(4, v); chk("R5 preset sweep", v, nv);
            wr(0, 1);
            first = 0;
            for (int k = 1; k <= nv + 4 && first == 0; k++) begin
                tick();
                rd(6, v);
                if (v[0]) first = k;
            end
            chk("R4 first underflow tick", first, nv + 2);
            rd(4, v); chk("R4 reload on underflow", v, nv);
            wr(6, 0);
            rd(6, v); chk("R6 write 0 keeps flag", v & 1, 1);
            wr(6, 1);
            rd(6, v); chk("R6 write 1 clears flag", v & 1, 0);
            second = 0;
            for (int k = 1; k <= nv + 4 && second == 0; k++) begin
                tick();
                rd(6, v);
                if (v[0]) second = k;
            end
            chk("R4 underflow period", second, nv + 1);
        end

        // R10 toggle and output gate
        stop_lo();
        wr(2, 1);
        wr(0, 2);
        @(negedge clk);
        t = int'(tout[0]);
        wr(0, 3);
        tick(); tick();
        chk("R10 no toggle before underflow", int'(tout[0]), t);
        tick();
        chk("R10 toggle on underflow", int'(tout[0]), t ^ 1);
        wr(0, 1);
        chk("R10 disabled output low", int'(tout[0]), 0);
        wr(0, 3);
        chk("R10 toggle state kept", int'(tout[0]), t ^ 1);
        stop_lo();

        // R9 event mode on the high channel
        wr(3, 3);
        rd(5, v); chk("R5 preset high", v, 3);
        wr(1, 5);
        rd(1, v); chk("R9 run immediate", v, 5);
        evt_edge();
        rd(5, v); chk("R9 one decrement per edge", v, 2);
        tick();
        rd(5, v); chk("R9 count tick ignored", v, 2);
        wr(1, 4);
        rd(1, v); chk("R9 stop immediate", v & 1, 0);
        evt_edge();
        rd(5, v); chk("R9 no decrement after stop", v, 2);
        wr(1, 0);
        wr(6, 3);

        // R7 / R8 chained mode
        wr(7, 1);
        wr(2, 2);
        wr(3, 1);
        rd(4, v); chk("R7 preset low", v, 2);
        wr(6, 3);
        wr(0, 1);
        tick(); tick(); tick();
        rd(4, v); chk("R7 low byte at 0100", v, 0);
        tick();
        rd(5, v); chk("R8 latched high byte", v, 1);
        rd(4, v); chk("R7 low wraps to FF", v, 'hFF);
        rd(5, v); chk("R7 high after borrow", v, 0);
        for (int k = 5; k <= 259; k++) tick();
        rd(6, v); chk("R7 no flag before 16-bit underflow", v, 0);
        tick();
        rd(6, v); chk("R7 high flag only", v, 2);
        chk("R6 irq output", int'(irq), 2);
        rd(4, v); chk("R7 low reload", v, 2);
        rd(5, v); chk("R7 high reload", v, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule